// File: doc/BRIEF.md
# Sync Command Decoder

This block sits behind the receiver of a serial sync link. It turns the 8-bit command codes that arrive on that link into reset actions. Each code marks the start of a command frame of fixed length. The block acts on the code only once that frame has run its full length, so every reset it generates is aligned to the frame period.

Three codes are recognised:
- The sync-reset code starts a long reset pulse, which is also passed on to downstream modules.
- The local-reset code pulses a reset that reaches only the modules in this crate. It is never passed downstream.
- The transceiver-reset code is passed downstream. It also starts a transceiver reset, which is held back until the clock manager reports lock and is then followed by a long quiet interval on the receive path.

Any other code is dropped.

The same block also launches commands that this unit sends itself. In master mode, an outgoing command waits for the next boundary of a free-running grid, which is 48 cycles (192 ns at 250 MHz) by default. In slave mode it leaves at once.

Top module: `sync_cmd_dec`

## Requirements
- R1: A `code_stb_i` sampled while no frame is running is accepted and starts a frame of `FRAME_CYC` cycles. Strobes on the `FRAME_CYC` edges that follow are ignored. The action for a code appears on the outputs after the edge that comes `FRAME_CYC+1` cycles after the accepting edge.
- R2: Code 8'hEE drives `sync_rst_o` high for exactly `SYNC_CYC` cycles. In its first cycle, `fwd_stb_o` pulses for one cycle with `fwd_code_o` = 8'hEE.
- R3: A further 8'hEE whose action lands while `sync_rst_o` is high restarts the count, so the pulse ends `SYNC_CYC` cycles after that later action.
- R4: Code 8'hDD drives `local_rst_o` high for exactly `LOCAL_CYC` cycles and never raises `fwd_stb_o`.
- R5: Code 8'h22 pulses `fwd_stb_o` with `fwd_code_o` = 8'h22. `xcvr_rst_o` stays low while `lock_i` is low. From the first edge that samples `lock_i` high, `xcvr_rst_o` is high for exactly `XRST_CYC` cycles.
- R6: Each transceiver reset sequence produces a single `xcvr_rst_o` pulse. 8'h22 actions that arrive while a sequence is waiting or running are dropped.
- R7: `rx_idle_o` is high during the transceiver reset and for `IDLE_CYC` cycles after it, for a total of `XRST_CYC+IDLE_CYC` cycles.
- R8: Any code other than 8'hEE, 8'hDD and 8'h22 produces no output activity.
- R9: With `master_i` high, `tx_start_o` (a one-cycle pulse carrying `tx_code_o`) rises only after an edge whose index since reset release is a multiple of `GRID_CYC`. It rises within `GRID_CYC` cycles of the request.
- R10: With `master_i` low, `tx_start_o` pulses in the cycle after the edge that samples `tx_req_i`, carrying `tx_code_i`.
- R11: A `tx_req_i` that arrives while an earlier request is still waiting for the grid is ignored.
- R12: While `rst_ni` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Link clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| code_stb_i | input | 1 | A received code is present |
| code_i | input | 8 | Received command code |
| lock_i | input | 1 | Clock manager lock, synchronous to `clk_i` |
| master_i | input | 1 | Unit is the sync master |
| tx_req_i | input | 1 | Request to send a command |
| tx_code_i | input | 8 | Command code to send |
| sync_rst_o | output | 1 | Long sync reset pulse |
| local_rst_o | output | 1 | Crate-local reset pulse |
| xcvr_rst_o | output | 1 | Transceiver reset |
| rx_idle_o | output | 1 | Force the receive path idle |
| fwd_stb_o | output | 1 | Code forwarded downstream |
| fwd_code_o | output | 8 | Forwarded code |
| tx_start_o | output | 1 | Launch of an outgoing command |
| tx_code_o | output | 8 | Code being launched |

## Verification
The bench builds the block with `FRAME_CYC`=6, `SYNC_CYC`=20, `LOCAL_CYC`=4, `XRST_CYC`=3, `IDLE_CYC`=15 and `GRID_CYC`=12.

With these values, the following can be checked cycle by cycle within a few dozen cycles:
- the end of a pulse and its restart by a second sync-reset code;
- the full quiet interval after a transceiver reset;
- several grid wraps for master launches.

With the defaults, the same checks would take thousands of cycles. The frame is short enough that a second code can land inside a pulse that is still running, and that a transceiver request can repeat while the first one is still waiting for lock.

// File: rtl/sync_cmd_pkg.sv
`timescale 1ns/1ps
package sync_cmd_pkg;
  typedef enum logic [7:0] {
    CMD_XCVR  = 8'h22,
    CMD_LOCAL = 8'hDD,
    CMD_SYNC  = 8'hEE
  } cmd_e;

  typedef enum logic [1:0] {
    XS_IDLE,
    XS_WAIT,
    XS_RST,
    XS_QUIET
  } xs_e;
endpackage

// File: rtl/sync_frame_rx.sv
`timescale 1ns/1ps
module sync_frame_rx
  import sync_cmd_pkg::*;
#(
  parameter int FRAME_CYC = 24
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       stb_i,
  input  logic [7:0] code_i,
  output logic       act_sync_o,
  output logic       act_local_o,
  output logic       act_xcvr_o,
  output logic [7:0] code_o
);
  localparam int CW = $clog2(FRAME_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(FRAME_CYC - 1);

  logic          busy_q;
  logic          done_q;
  logic [CW-1:0] cnt_q;
  logic [7:0]    code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      code_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (stb_i) begin
          busy_q <= 1'b1;
          cnt_q  <= LAST;
          code_q <= code_i;
        end
      end else if (cnt_q == '0) begin
        // the action fires only once the full frame has elapsed
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign act_sync_o  = done_q && (code_q == CMD_SYNC);
  assign act_local_o = done_q && (code_q == CMD_LOCAL);
  assign act_xcvr_o  = done_q && (code_q == CMD_XCVR);
  assign code_o      = code_q;
endmodule

// File: rtl/sync_pulse_gen.sv
`timescale 1ns/1ps
module sync_pulse_gen #(
  parameter int LEN = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic pulse_o
);
  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (trig_i) begin
      // a new trigger restarts the full length
      cnt_q <= CW'(LEN);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign pulse_o = (cnt_q != '0);
endmodule

// File: rtl/sync_xcvr_seq.sv
`timescale 1ns/1ps
module sync_xcvr_seq
  import sync_cmd_pkg::*;
#(
  parameter int XRST_CYC = 16,
  parameter int IDLE_CYC = 250000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic lock_i,
  output logic xrst_o,
  output logic idle_o
);
  localparam int MAXC = (IDLE_CYC > XRST_CYC) ? IDLE_CYC : XRST_CYC;
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] XRST_LAST = CW'(XRST_CYC - 1);
  localparam logic [CW-1:0] IDLE_LAST = CW'(IDLE_CYC - 1);

  xs_e           st_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= XS_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        XS_IDLE: begin
          if (req_i) st_q <= XS_WAIT;
        end
        XS_WAIT: begin
          if (lock_i) begin
            st_q  <= XS_RST;
            cnt_q <= XRST_LAST;
          end
        end
        XS_RST: begin
          if (cnt_q == '0) begin
            st_q  <= XS_QUIET;
            cnt_q <= IDLE_LAST;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        XS_QUIET: begin
          if (cnt_q == '0) st_q <= XS_IDLE;
          else             cnt_q <= cnt_q - 1'b1;
        end
        default: st_q <= XS_IDLE;
      endcase
    end
  end

  assign xrst_o = (st_q == XS_RST);
  assign idle_o = (st_q == XS_RST) || (st_q == XS_QUIET);
endmodule

// File: rtl/sync_tx_align.sv
`timescale 1ns/1ps
module sync_tx_align #(
  parameter int GRID_CYC = 48
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       master_i,
  input  logic       req_i,
  input  logic [7:0] code_i,
  output logic       start_o,
  output logic [7:0] code_o,
  output logic       tick_o
);
  localparam int GW = $clog2(GRID_CYC);
  localparam logic [GW-1:0] GRID_LAST = GW'(GRID_CYC - 1);

  logic [GW-1:0] grid_q;
  logic          pend_q;
  logic [7:0]    pend_code_q;

  assign tick_o = (grid_q == GRID_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grid_q <= '0;
    end else if (tick_o) begin
      grid_q <= '0;
    end else begin
      grid_q <= grid_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      pend_code_q <= '0;
      start_o     <= 1'b0;
      code_o      <= '0;
    end else begin
      start_o <= 1'b0;
      if (pend_q) begin
        // while one request waits, further requests are dropped
        if (tick_o || !master_i) begin
          start_o <= 1'b1;
          code_o  <= pend_code_q;
          pend_q  <= 1'b0;
        end
      end else if (req_i) begin
        if (!master_i || tick_o) begin
          start_o <= 1'b1;
          code_o  <= code_i;
        end else begin
          pend_q      <= 1'b1;
          pend_code_q <= code_i;
        end
      end
    end
  end
endmodule

// File: rtl/sync_cmd_dec.sv
`timescale 1ns/1ps
module sync_cmd_dec
  import sync_cmd_pkg::*;
#(
  parameter int FRAME_CYC = 24,
  parameter int SYNC_CYC  = 1000,
  parameter int LOCAL_CYC = 8,
  parameter int XRST_CYC  = 16,
  parameter int IDLE_CYC  = 250000,
  parameter int GRID_CYC  = 48
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       code_stb_i,
  input  logic [7:0] code_i,
  input  logic       lock_i,
  input  logic       master_i,
  input  logic       tx_req_i,
  input  logic [7:0] tx_code_i,
  output logic       sync_rst_o,
  output logic       local_rst_o,
  output logic       xcvr_rst_o,
  output logic       rx_idle_o,
  output logic       fwd_stb_o,
  output logic [7:0] fwd_code_o,
  output logic       tx_start_o,
  output logic [7:0] tx_code_o
);
  logic       act_sync;
  logic       act_local;
  logic       act_xcvr;
  logic [7:0] act_code;
  logic       grid_tick;

  sync_frame_rx #(.FRAME_CYC(FRAME_CYC)) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stb_i       (code_stb_i),
    .code_i      (code_i),
    .act_sync_o  (act_sync),
    .act_local_o (act_local),
    .act_xcvr_o  (act_xcvr),
    .code_o      (act_code)
  );

  sync_pulse_gen #(.LEN(SYNC_CYC)) u_sync_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .trig_i  (act_sync),
    .pulse_o (sync_rst_o)
  );

  sync_pulse_gen #(.LEN(LOCAL_CYC)) u_local_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .trig_i  (act_local),
    .pulse_o (local_rst_o)
  );

  sync_xcvr_seq #(.XRST_CYC(XRST_CYC), .IDLE_CYC(IDLE_CYC)) u_xcvr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (act_xcvr),
    .lock_i (lock_i),
    .xrst_o (xcvr_rst_o),
    .idle_o (rx_idle_o)
  );

  // the local-only code is never forwarded
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fwd_stb_o  <= 1'b0;
      fwd_code_o <= '0;
    end else begin
      fwd_stb_o <= act_sync || act_xcvr;
      if (act_sync || act_xcvr) fwd_code_o <= act_code;
    end
  end

  sync_tx_align #(.GRID_CYC(GRID_CYC)) u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .master_i (master_i),
    .req_i    (tx_req_i),
    .code_i   (tx_code_i),
    .start_o  (tx_start_o),
    .code_o   (tx_code_o),
    .tick_o   (grid_tick)
  );
endmodule

// File: rtl/sync_cmd_dec_chk.sv
`timescale 1ns/1ps
module sync_cmd_dec_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       lock_i,
  input logic       master_i,
  input logic       act_sync_i,
  input logic       act_local_i,
  input logic       act_xcvr_i,
  input logic       grid_tick_i,
  input logic       sync_rst_o,
  input logic       local_rst_o,
  input logic       xcvr_rst_o,
  input logic       rx_idle_o,
  input logic       fwd_stb_o,
  input logic [7:0] fwd_code_o,
  input logic       tx_start_o
);
  AST_SYNC_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_sync_i |=> sync_rst_o && fwd_stb_o); // R2
  AST_LOCAL_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_local_i |=> local_rst_o && !fwd_stb_o); // R4
  AST_NO_FWD_LOCAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_stb_o |-> fwd_code_o != 8'hDD); // R4
  AST_XREQ_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_xcvr_i |=> fwd_stb_o && fwd_code_o == 8'h22); // R5
  AST_XRST_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(xcvr_rst_o) |-> $past(lock_i)); // R5
  AST_IDLE_COVERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xcvr_rst_o |-> rx_idle_o); // R7
  AST_GRID_LAUNCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o && $past(master_i) |-> $past(grid_tick_i)); // R9
endmodule

bind sync_cmd_dec sync_cmd_dec_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .lock_i      (lock_i),
  .master_i    (master_i),
  .act_sync_i  (act_sync),
  .act_local_i (act_local),
  .act_xcvr_i  (act_xcvr),
  .grid_tick_i (grid_tick),
  .sync_rst_o  (sync_rst_o),
  .local_rst_o (local_rst_o),
  .xcvr_rst_o  (xcvr_rst_o),
  .rx_idle_o   (rx_idle_o),
  .fwd_stb_o   (fwd_stb_o),
  .fwd_code_o  (fwd_code_o),
  .tx_start_o  (tx_start_o)
);

// File: tb/sync_cmd_dec_tb.sv
`timescale 1ns/1ps
module sync_cmd_dec_tb;
  localparam int FRAME = 6;
  localparam int SYNC  = 20;
  localparam int LOCAL = 4;
  localparam int XRST  = 3;
  localparam int IDLE  = 15;
  localparam int GRID  = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       code_stb = 1'b0;
  logic [7:0] code = '0;
  logic       lock = 1'b0;
  logic       master = 1'b0;
  logic       tx_req = 1'b0;
  logic [7:0] tx_code = '0;
  logic       sync_rst, local_rst, xcvr_rst, rx_idle, fwd_stb, tx_start;
  logic [7:0] fwd_code, tx_code_o;

  int checks = 0;
  int errors = 0;
  int ecnt = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) ecnt <= 0;
    else        ecnt <= ecnt + 1;
  end

  sync_cmd_dec #(
    .FRAME_CYC(FRAME), .SYNC_CYC(SYNC), .LOCAL_CYC(LOCAL),
    .XRST_CYC(XRST), .IDLE_CYC(IDLE), .GRID_CYC(GRID)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .code_stb_i(code_stb), .code_i(code),
    .lock_i(lock), .master_i(master), .tx_req_i(tx_req), .tx_code_i(tx_code),
    .sync_rst_o(sync_rst), .local_rst_o(local_rst), .xcvr_rst_o(xcvr_rst),
    .rx_idle_o(rx_idle), .fwd_stb_o(fwd_stb), .fwd_code_o(fwd_code),
    .tx_start_o(tx_start), .tx_code_o(tx_code_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // ends at the falling edge after the accepting edge
  task automatic send_code(input logic [7:0] c);
    @(negedge clk);
    code_stb = 1'b1;
    code = c;
    @(posedge clk);
    @(negedge clk);
    code_stb = 1'b0;
  endtask

  task automatic t_reset();
    int any;
    any = sync_rst | local_rst | xcvr_rst | rx_idle | fwd_stb | tx_start |
          (|fwd_code) | (|tx_code_o);
    chk(any == 0, "R12 outputs in reset", any, 0);
  endtask

  task automatic t_sync();
    int n;
    send_code(8'hEE);
    step(FRAME);
    chk(sync_rst == 1'b0, "R1 no action before frame end", sync_rst, 0);
    step(1);
    chk(sync_rst == 1'b1, "R1 action at frame end", sync_rst, 1);
    chk(fwd_stb && fwd_code == 8'hEE, "R2 forward EE", fwd_code, 8'hEE);
    n = 0;
    while (sync_rst && n < 3 * SYNC) begin n++; step(1); end
    chk(n == SYNC, "R2 sync pulse length", n, SYNC);
  endtask

  task automatic t_retrig();
    int n;
    send_code(8'hEE);
    step(FRAME + 1 + 8);
    send_code(8'hEE);
    step(FRAME);
    chk(sync_rst == 1'b1, "R3 pulse still high", sync_rst, 1);
    step(1);
    n = 0;
    while (sync_rst && n < 3 * SYNC) begin n++; step(1); end
    chk(n == SYNC, "R3 restarted length", n, SYNC);
  endtask

  task automatic t_local();
    int n;
    int f;
    send_code(8'hDD);
    step(FRAME + 1);
    chk(local_rst == 1'b1, "R4 local reset start", local_rst, 1);
    n = 0;
    f = 0;
    for (int i = 0; i < 3 * LOCAL; i++) begin
      if (local_rst) n++;
      if (fwd_stb) f++;
      step(1);
    end
    chk(n == LOCAL, "R4 local pulse length", n, LOCAL);
    chk(f == 0, "R4 not forwarded", f, 0);
  endtask

  task automatic t_frame_guard();
    int l;
    send_code(8'hEE);
    code_stb = 1'b1;
    code = 8'hDD;
    @(posedge clk);
    @(negedge clk);
    code_stb = 1'b0;
    step(FRAME);
    chk(sync_rst && fwd_code == 8'hEE, "R1 first code wins", fwd_code, 8'hEE);
    l = 0;
    for (int i = 0; i < FRAME + 2 * LOCAL; i++) begin
      if (local_rst) l++;
      step(1);
    end
    chk(l == 0, "R1 strobe inside frame ignored", l, 0);
    step(SYNC);
  endtask

  task automatic t_xcvr();
    int rises;
    int nx;
    int ni;
    logic prev;
    lock = 1'b0;
    send_code(8'h22);
    step(FRAME + 1);
    chk(fwd_stb && fwd_code == 8'h22, "R5 forward 22", fwd_code, 8'h22);
    chk(xcvr_rst == 1'b0, "R5 held without lock", xcvr_rst, 0);
    send_code(8'h22);
    step(FRAME + 3);
    chk(xcvr_rst == 1'b0, "R5 still held", xcvr_rst, 0);
    lock = 1'b1;
    step(1);
    chk(xcvr_rst == 1'b1, "R5 starts after lock", xcvr_rst, 1);
    rises = 1;
    nx = 0;
    ni = 0;
    prev = 1'b1;
    for (int i = 0; i < 4 * (XRST + IDLE); i++) begin
      if (xcvr_rst) nx++;
      if (rx_idle) ni++;
      if (xcvr_rst && !prev) rises++;
      prev = xcvr_rst;
      step(1);
    end
    chk(nx == XRST, "R5 reset length", nx, XRST);
    chk(rises == 1, "R6 single reset pulse", rises, 1);
    chk(ni == XRST + IDLE, "R7 idle length", ni, XRST + IDLE);
  endtask

  task automatic t_unknown();
    int any;
    send_code(8'h55);
    any = 0;
    for (int i = 0; i < FRAME + 6; i++) begin
      any += sync_rst + local_rst + xcvr_rst + rx_idle + fwd_stb;
      step(1);
    end
    chk(any == 0, "R8 unknown code silent", any, 0);
  endtask

  task automatic t_master(input int offset, input logic [7:0] c);
    int w;
    master = 1'b1;
    step(offset);
    tx_req = 1'b1;
    tx_code = c;
    @(posedge clk);
    @(negedge clk);
    tx_req = 1'b0;
    w = 0;
    while (!tx_start && w <= GRID + 2) begin w++; step(1); end
    chk(tx_start == 1'b1 && w <= GRID, "R9 launch within grid", w, GRID);
    chk(ecnt % GRID == 0, "R9 launch on grid", ecnt % GRID, 0);
    chk(tx_code_o == c, "R9 launch code", tx_code_o, c);
  endtask

  task automatic t_pending();
    int s;
    logic [7:0] got;
    // after a launch the next boundary is far away
    tx_req = 1'b1;
    tx_code = 8'hA1;
    @(posedge clk);
    @(negedge clk);
    tx_code = 8'hB2;
    @(posedge clk);
    @(negedge clk);
    tx_req = 1'b0;
    s = 0;
    got = '0;
    for (int i = 0; i < 2 * GRID + 2; i++) begin
      if (tx_start) begin s++; got = tx_code_o; end
      step(1);
    end
    chk(s == 1, "R11 one launch", s, 1);
    chk(got == 8'hA1, "R11 first request kept", got, 8'hA1);
  endtask

  task automatic t_slave();
    master = 1'b0;
    step(3);
    tx_req = 1'b1;
    tx_code = 8'h3C;
    @(posedge clk);
    @(negedge clk);
    tx_req = 1'b0;
    chk(tx_start && tx_code_o == 8'h3C, "R10 immediate launch", tx_code_o, 8'h3C);
    step(1);
    chk(tx_start == 1'b0, "R10 one-cycle pulse", tx_start, 0);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    t_reset();
    rst_n = 1'b1;
    step(2);
    t_sync();
    t_retrig();
    t_local();
    t_frame_guard();
    t_xcvr();
    t_unknown();
    t_master(0, 8'h5A);
    t_master(5, 8'h71);
    t_master(11, 8'h0F);
    t_pending();
    t_slave();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule